// File: doc/BRIEF.md
# Sequence-Unlocked Functional Locking FSM

This block is a startup gate for a protected datapath. Coming out of reset, it is locked. It compares a stream of input patterns, one per strobed clock, against an expected chain of words. Each expected word is a stored unlock word combined with a chip-unique identifier. That identifier is a static input, so every chip needs its own sequence.

The whole chain must be presented in order. When it is, the controller reaches its functional state, and the protected adder's result leaves the block unaltered. A single wrong pattern at any step sends the controller into a trap state. No input leaves a trap state; only reset does. While the block is locked or trapped it keeps running, but its output is XORed with a nonzero mask that depends on the state. No error of any kind is signalled.

The trap states reuse state encodings that the unlock path never reaches, so they add no flip-flops.

Top module: `seq_lock_gate`

## Requirements
- R1: After reset the block is at lock step 0 and `unlocked` is 0.
- R2: The pattern expected at step i (0..3) is stored word i XOR `chip_id` rotated left by i bits. With the default parameters, the stored words for steps 0, 1, 2 and 3 are 8'h5A, 8'hE1, 8'h96 and 8'h3C.
- R3: A pattern is sampled only on a rising clock edge while `pat_valid` is 1. While `pat_valid` is 0 the lock step does not change, whatever `pat_in` holds.
- R4: When the correct pattern arrives at the last step, `unlocked` becomes 1 at the following clock edge. From then on `data_out` equals `op_a + op_b` modulo 256.
- R5: A wrong pattern at any step sends the block to the trap state at the next edge, and `unlocked` stays 0.
- R6: The trap state is left only by reset. Any later pattern sequence, including the correct one, keeps the block trapped.
- R7: While locked at step k, `data_out` is `(op_a + op_b)` XOR the mask 8'hA5 rotated left by k. In the trap state, the mask is 8'hA5 rotated left by 5, which is 8'hB4.
- R8: Once unlocked, the block stays unlocked until reset, and further patterns have no effect on `data_out`.
- R9: A sequence built for one chip identifier traps the block when `chip_id` holds a different identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_valid | input | 1 | Strobe: sample `pat_in` this cycle |
| pat_in | input | 8 | Unlock pattern |
| chip_id | input | 8 | Static per-chip identifier |
| op_a | input | 8 | Datapath operand A |
| op_b | input | 8 | Datapath operand B |
| data_out | output | 8 | Masked datapath result |
| unlocked | output | 1 | High once the full sequence has been accepted |

## Verification
The in-RTL assertions are checked on every cycle. They cover four things:
- a mismatch always leads to a trap;
- the trap and the functional state never change;
- the step holds while no pattern is strobed;
- the output is unaltered exactly when unlocked, and altered otherwise.

The exact mask values, the per-identifier sequence derivation and the recovery by reset after a trap can only be shown by the bench's scenarios. So can the result that one chip's sequence fails on another chip.

// File: rtl/seq_lock_pkg.sv
package seq_lock_pkg;
   typedef enum logic [1:0] {
      PH_LOCK = 2'd0,
      PH_OPEN = 2'd1,
      PH_TRAP = 2'd2
   } phase_t;
endpackage

// File: rtl/seq_key_expander.sv
module seq_key_expander #(
   parameter int          PAT_W      = 8,
   parameter int          STEPS      = 4,
   parameter int          IDX_W      = 2,
   parameter logic [STEPS*PAT_W-1:0] UNLOCK_SEQ = '0
) (
   input  logic [PAT_W-1:0] chip_id,
   input  logic [IDX_W-1:0] step,
   output logic [PAT_W-1:0] expected
);
   logic [PAT_W-1:0] exp_tbl [STEPS];

   for (genvar i = 0; i < STEPS; i++) begin : g_step
      localparam int ROT = i % PAT_W;
      logic [PAT_W-1:0] rot_id;
      if (ROT == 0) begin : g_norot
         assign rot_id = chip_id;
      end else begin : g_rot
         assign rot_id = (chip_id << ROT) | (chip_id >> (PAT_W - ROT));
      end
      assign exp_tbl[i] = UNLOCK_SEQ[i*PAT_W +: PAT_W] ^ rot_id;
   end

   assign expected = exp_tbl[step];
endmodule

// File: rtl/seq_lock_fsm.sv
module seq_lock_fsm
   import seq_lock_pkg::*;
#(
   parameter int PAT_W = 8,
   parameter int STEPS = 4,
   parameter int SW    = 3,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_valid,
   input  logic [PAT_W-1:0] pat_in,
   input  logic [PAT_W-1:0] expected,
   output logic [SW-1:0]    state,
   output logic [IDX_W-1:0] step,
   output phase_t           phase
);
   localparam logic [SW-1:0] OPEN_CODE = SW'(STEPS);
   localparam logic [SW-1:0] TRAP_CODE = SW'(STEPS + 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= '0;
      end else if (state < OPEN_CODE && pat_valid) begin
         if (pat_in == expected) state <= state + 1'b1;
         else                    state <= TRAP_CODE;
      end
   end

   always_comb begin
      if (state < OPEN_CODE)       phase = PH_LOCK;
      else if (state == OPEN_CODE) phase = PH_OPEN;
      else                         phase = PH_TRAP;
   end

   assign step = state[IDX_W-1:0];

   a_r5_mismatch_traps: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOCK && pat_valid && pat_in != expected) |=> phase == PH_TRAP);
   a_r6_trap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_TRAP |=> phase == PH_TRAP);
   a_r8_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_OPEN |=> phase == PH_OPEN);
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOCK && !pat_valid) |=> $stable(state));
endmodule

// File: rtl/seq_mask_gen.sv
module seq_mask_gen #(
   parameter int               PAT_W     = 8,
   parameter int               STEPS     = 4,
   parameter int               SW        = 3,
   parameter logic [PAT_W-1:0] MASK_SEED = 8'hA5
) (
   input  logic [SW-1:0]    state,
   output logic [PAT_W-1:0] mask
);
   localparam int NCODES = 1 << SW;
   logic [PAT_W-1:0] mask_tbl [NCODES];

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      localparam int ROT = c % PAT_W;
      if (c == STEPS) begin : g_open
         assign mask_tbl[c] = '0;
      end else if (ROT == 0) begin : g_norot
         assign mask_tbl[c] = MASK_SEED;
      end else begin : g_rot
         assign mask_tbl[c] = (MASK_SEED << ROT) | (MASK_SEED >> (PAT_W - ROT));
      end
   end

   assign mask = mask_tbl[state];
endmodule

// File: rtl/seq_sample_dp.sv
module seq_sample_dp #(
   parameter int PAT_W = 8
) (
   input  logic [PAT_W-1:0] op_a,
   input  logic [PAT_W-1:0] op_b,
   output logic [PAT_W-1:0] result
);
   assign result = op_a + op_b;
endmodule

// File: rtl/seq_lock_gate.sv
module seq_lock_gate
   import seq_lock_pkg::*;
#(
   parameter int               PAT_W      = 8,
   parameter int               STEPS      = 4,
   parameter logic [STEPS*PAT_W-1:0] UNLOCK_SEQ = 32'h3C96_E15A,
   parameter logic [PAT_W-1:0] MASK_SEED  = 8'hA5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pat_valid,
   input  logic [PAT_W-1:0] pat_in,
   input  logic [PAT_W-1:0] chip_id,
   input  logic [PAT_W-1:0] op_a,
   input  logic [PAT_W-1:0] op_b,
   output logic [PAT_W-1:0] data_out,
   output logic             unlocked
);
   localparam int SW    = $clog2(STEPS + 2);
   localparam int IDX_W = $clog2(STEPS);

   if (STEPS < 2) begin : g_chk_steps
      $error("STEPS must be at least 2");
   end
   if (MASK_SEED == '0) begin : g_chk_seed
      $error("MASK_SEED must be nonzero");
   end
   if (PAT_W < 2) begin : g_chk_width
      $error("PAT_W must be at least 2");
   end

   logic [SW-1:0]    state;
   logic [IDX_W-1:0] step;
   phase_t           phase;
   logic [PAT_W-1:0] expected, mask, dp_res;

   seq_key_expander #(.PAT_W(PAT_W), .STEPS(STEPS), .IDX_W(IDX_W), .UNLOCK_SEQ(UNLOCK_SEQ)) u_key (
      .chip_id(chip_id), .step(step), .expected(expected));

   seq_lock_fsm #(.PAT_W(PAT_W), .STEPS(STEPS), .SW(SW), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_in(pat_in),
      .expected(expected), .state(state), .step(step), .phase(phase));

   seq_mask_gen #(.PAT_W(PAT_W), .STEPS(STEPS), .SW(SW), .MASK_SEED(MASK_SEED)) u_mask (
      .state(state), .mask(mask));

   seq_sample_dp #(.PAT_W(PAT_W)) u_dp (
      .op_a(op_a), .op_b(op_b), .result(dp_res));

   assign data_out = dp_res ^ mask;
   assign unlocked = (phase == PH_OPEN);

   a_r4_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked |-> data_out == dp_res);
   a_r7_locked_altered: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> data_out != dp_res);
endmodule

// File: tb/seq_lock_gate_test.sv
module seq_lock_gate_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pat_valid = 1'b0;
   logic [7:0] pat_in = '0, chip_id = '0, op_a = '0, op_b = '0;
   logic [7:0] data_out;
   logic unlocked;
   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   seq_lock_gate uut (
      .clk(clk), .rst_n(rst_n), .pat_valid(pat_valid), .pat_in(pat_in),
      .chip_id(chip_id), .op_a(op_a), .op_b(op_b),
      .data_out(data_out), .unlocked(unlocked));

   localparam logic [7:0] WORDS [4] = '{8'h5A, 8'hE1, 8'h96, 8'h3C};
   // rows: chip_id, op_a, op_b
   localparam logic [23:0] VEC [4] = '{24'h00_10_20, 24'h3C_FF_02, 24'hC3_80_80, 24'h01_7E_11};

   function automatic logic [7:0] rotl(input logic [7:0] x, input int n);
      logic [7:0] r = x;
      for (int k = 0; k < n; k++) r = {r[6:0], r[7]};
      return r;
   endfunction

   function automatic logic [7:0] exp_pat(input logic [7:0] id, input int i);
      return WORDS[i] ^ rotl(id, i);
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; pat_valid = 1'b0;
      @(posedge clk); @(posedge clk); #2;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic send(input logic v, input logic [7:0] p);
      @(negedge clk); pat_valid = v; pat_in = p;
      @(posedge clk); #2; pat_valid = 1'b0;
   endtask

   function automatic logic [7:0] sum();
      return op_a + op_b;
   endfunction

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      op_a = 8'h12; op_b = 8'h34; chip_id = 8'h00;
      do_reset(); #2;
      chk("R1 unlocked after reset", {7'd0, unlocked}, 8'h00);
      chk("R7 mask at step 0", data_out, sum() ^ 8'hA5);

      // R2 R4 R7 table walk: correct unlock for several ids
      foreach (VEC[r]) begin
         chip_id = VEC[r][23:16]; op_a = VEC[r][15:8]; op_b = VEC[r][7:0];
         do_reset();
         for (int i = 0; i < 4; i++) begin
            send(1'b1, exp_pat(chip_id, i));
            if (i < 3) begin
               chk("R7 locked mask at step", data_out, sum() ^ rotl(8'hA5, i + 1));
               chk("R2 still locked mid-sequence", {7'd0, unlocked}, 8'h00);
            end
         end
         chk("R4 unlocked after last pattern", {7'd0, unlocked}, 8'h01);
         chk("R4 datapath passes unaltered", data_out, sum());
      end

      // R8 unlocked ignores later patterns
      for (int k = 0; k < 4; k++) send(1'b1, 8'h55 + 8'(k));
      chk("R8 stays unlocked", {7'd0, unlocked}, 8'h01);
      op_a = 8'hF0; op_b = 8'h20; #1;
      chk("R8 output unaltered", data_out, 8'h10);

      // R3 no strobe holds the step
      chip_id = 8'h5A; do_reset();
      send(1'b1, exp_pat(chip_id, 0));
      for (int k = 0; k < 3; k++) send(1'b0, 8'hFF);
      chk("R3 step held without strobe", data_out, sum() ^ rotl(8'hA5, 1));
      for (int i = 1; i < 4; i++) send(1'b1, exp_pat(chip_id, i));
      chk("R3 unlock completes after gap", {7'd0, unlocked}, 8'h01);

      // R5 wrong pattern at each position traps
      for (int pos = 0; pos < 4; pos++) begin
         chip_id = 8'hA7; do_reset();
         for (int i = 0; i < pos; i++) send(1'b1, exp_pat(chip_id, i));
         send(1'b1, exp_pat(chip_id, pos) ^ 8'h01);
         chk("R5 trapped after mismatch", data_out, sum() ^ 8'hB4);
         chk("R5 not unlocked", {7'd0, unlocked}, 8'h00);
      end

      // R6 trap persists under correct sequence and idle
      for (int i = 0; i < 4; i++) send(1'b1, exp_pat(chip_id, i));
      for (int k = 0; k < 5; k++) send(1'b0, 8'h00);
      chk("R6 trap persists", data_out, sum() ^ 8'hB4);
      chk("R6 never unlocked", {7'd0, unlocked}, 8'h00);
      do_reset();
      for (int i = 0; i < 4; i++) send(1'b1, exp_pat(chip_id, i));
      chk("R6 reset clears trap", {7'd0, unlocked}, 8'h01);

      // R9 sequence for one id fails on another
      chip_id = 8'hC3; do_reset();
      for (int i = 0; i < 4; i++) send(1'b1, exp_pat(8'h3C, i));
      chk("R9 foreign sequence traps", data_out, sum() ^ 8'hB4);
      chk("R9 foreign sequence not unlocked", {7'd0, unlocked}, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule